// File: doc/BRIEF.md
# Black Level Averaging Offset Loop

This block closes a slow control loop around the black level of a digitized video line. On every line, a clamp pulse opens a fresh averaging cycle. The block then sums the pixel samples that arrive while the black-window strobe is high, up to a programmed window length of 16, 32, 64 or 128 pixels. The average is taken with a right shift; there is no divider.

At the line-end strobe, the block compares that average with a black target. The difference is added into a signed fixed-point filter state, scaled so that the loop time constant is 2^(5+code) lines. A line that did not fill its window is thrown away.

The integer part of the filter state drives a signed offset word. That word is reloaded only on a clamp pulse, so a downstream offset converter always changes at the same point of the line.

The pixel input is a valid/ready stream. The block never applies back-pressure: `pix_ready` is low during reset and stays high from the first clock after reset. A sample is consumed on every cycle where `pix_valid` and `pix_ready` are both high. Samples outside the window, or beyond the programmed count, are consumed and dropped. All other pins are plain level or single-cycle strobe signals sampled on the rising clock edge.

Top module: `bla_offset_loop`

## Requirements
- R1: While `rst_n` is low, `offset_out` is 0, the filter state is 0 and `pix_ready` is 0.
- R2: The window length N is set by `win_code`: 00 gives 16, 01 gives 32, 10 gives 64 and 11 gives 128. A sample counts only when `win_en`, `pix_valid` and `pix_ready` are all high. Once N samples have been counted in a line, further samples are ignored.
- R3: The line average is the sum of the N counted samples shifted right by log2(N), which rounds down.
- R4: At `line_end`, when the line is full and the loop is enabled, the filter state (12 fraction bits) gains (`black_target` − average) × 2^(7 − `tc_code`). This gives a time constant of 2^(5+`tc_code`) lines: 000 is 32 lines, 100 is 512 lines and 111 is 4096 lines.
- R5: `offset_out` changes only in the cycle after a `clamp_pulse`. It then takes floor(state / 4096), the signed integer part of the filter state.
- R6: A `clamp_pulse` clears the sample sum and count, which starts a new averaging cycle. A sample presented in the same cycle as the clamp is dropped. `line_end` also clears the sum and count after it is evaluated.
- R7: A `line_end` with fewer than N counted samples leaves the filter state unchanged.
- R8: With `loop_off` = 1, the filter state is frozen. A clamp still reloads `offset_out` from the frozen state.
- R9: The filter state saturates at its signed limits instead of wrapping. As a result, `offset_out` stops at +511 and −512.
- R10: `pix_ready` is 1 in every cycle after reset, so no sample is ever held back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_data | input | 8 | Digitized pixel sample |
| pix_valid | input | 1 | Sample present on `pix_data` |
| pix_ready | output | 1 | Block accepts samples (always 1 after reset) |
| win_en | input | 1 | High during the black window of the line |
| line_end | input | 1 | Single-cycle end-of-line strobe |
| clamp_pulse | input | 1 | Single-cycle clamp leading-edge pulse |
| loop_off | input | 1 | 1 freezes the loop |
| win_code | input | 2 | Window length code |
| tc_code | input | 3 | Time-constant code |
| black_target | input | 8 | Black level target |
| offset_out | output | 10 | Signed offset correction word |

## Verification
The assertions rely on three input conventions. `win_code` and `tc_code` stay constant between a clamp and the next line end. `clamp_pulse` and `line_end` are single-cycle strobes. `clamp_pulse` never coincides with a sample that is still expected to count.

The stimulus follows these conventions. It changes codes only before the clamp that opens a line and raises each strobe for exactly one cycle. It opens the window a few cycles after the clamp and closes it before `line_end`.

Random lines vary the window, the time constant, the target, the pixel levels and the gaps in `pix_valid`. Some lines are deliberately short and some run with the loop disabled. Directed runs drive the state into both saturation limits and overfill a window with outlier samples.

// File: rtl/bla_pkg.sv
package bla_pkg;
  localparam int WIN_LOG_MIN = 4;  // shortest window is 2^4 pixels
  localparam int WIN_CODE_W  = 2;
  localparam int TC_LOG_MIN  = 5;  // shortest time constant is 2^5 lines
  localparam int TC_CODE_W   = 3;
  localparam int TC_N        = 1 << TC_CODE_W;
  localparam int FRAC_W      = TC_LOG_MIN + TC_N - 1;  // exact at the slowest setting
endpackage

// File: rtl/bla_window_avg.sv
module bla_window_avg
  import bla_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PIX_W-1:0]      pix_data,
  input  logic                  take,
  input  logic                  clamp,
  input  logic                  line_end,
  input  logic [WIN_CODE_W-1:0] win_code,
  output logic [PIX_W-1:0]      avg,
  output logic                  line_full
);
  localparam int WIN_LOG_MAX = WIN_LOG_MIN + (1 << WIN_CODE_W) - 1;
  localparam int CNT_W       = WIN_LOG_MAX + 1;
  localparam int SUM_W       = PIX_W + WIN_LOG_MAX;
  localparam int SH_W        = $clog2(WIN_LOG_MAX + 1);

  logic [SH_W-1:0]  shamt;
  logic [CNT_W-1:0] cnt, cnt_goal;
  logic [SUM_W-1:0] sum;
  logic             accept;

  assign shamt     = SH_W'(WIN_LOG_MIN) + SH_W'(win_code);
  assign cnt_goal  = CNT_W'(1) << shamt;
  assign line_full = (cnt == cnt_goal);
  assign accept    = take && (cnt < cnt_goal);
  assign avg       = PIX_W'(sum >> shamt);

  always_ff @(posedge clk) begin
    if (!rst_n || clamp || line_end) begin
      cnt <= '0;
      sum <= '0;
    end else if (accept) begin
      cnt <= cnt + CNT_W'(1);
      sum <= sum + SUM_W'(pix_data);
    end
  end

  AST_EXTRA_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (take && line_full && !clamp && !line_end) |=> $stable(sum));  // R2
  AST_CLAMP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clamp |=> (cnt == '0 && sum == '0));  // R6
endmodule

// File: rtl/bla_loop_filter.sv
module bla_loop_filter
  import bla_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int STATE_W = 22
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [PIX_W-1:0]          avg,
  input  logic [PIX_W-1:0]          target,
  input  logic                      line_end,
  input  logic                      line_full,
  input  logic                      loop_off,
  input  logic [TC_CODE_W-1:0]      tc_code,
  output logic signed [STATE_W-1:0] state
);
  localparam logic signed [STATE_W:0] HI = {2'b00, {(STATE_W-1){1'b1}}};
  localparam logic signed [STATE_W:0] LO = {2'b11, {(STATE_W-1){1'b0}}};

  logic signed [PIX_W:0]     err;
  logic signed [STATE_W-1:0] err_ext, delta;
  logic [TC_CODE_W-1:0]      up;
  logic signed [STATE_W:0]   wide;
  logic signed [STATE_W-1:0] next;
  logic                      update;

  assign err     = $signed({1'b0, target}) - $signed({1'b0, avg});
  assign err_ext = {{(STATE_W-PIX_W-1){err[PIX_W]}}, err};
  assign up      = TC_CODE_W'(TC_N - 1) - tc_code;
  assign delta   = err_ext <<< up;
  assign wide    = {state[STATE_W-1], state} + {delta[STATE_W-1], delta};
  assign update  = line_end && line_full && !loop_off;

  always_comb begin
    if (wide > HI)      next = HI[STATE_W-1:0];
    else if (wide < LO) next = LO[STATE_W-1:0];
    else                next = wide[STATE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      state <= '0;
    else if (update) state <= next;
  end

  AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    loop_off |=> $stable(state));  // R8
  AST_SHORT_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && !line_full) |=> $stable(state));  // R7
  AST_NO_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (update && !state[STATE_W-1] && !delta[STATE_W-1]) |=> !state[STATE_W-1]);  // R9
  AST_NO_WRAP_DN: assert property (@(posedge clk) disable iff (!rst_n)
    (update && state[STATE_W-1] && delta[STATE_W-1]) |=> state[STATE_W-1]);  // R9
endmodule

// File: rtl/bla_offset_loop.sv
module bla_offset_loop
  import bla_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int OFF_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PIX_W-1:0]      pix_data,
  input  logic                  pix_valid,
  output logic                  pix_ready,
  input  logic                  win_en,
  input  logic                  line_end,
  input  logic                  clamp_pulse,
  input  logic                  loop_off,
  input  logic [WIN_CODE_W-1:0] win_code,
  input  logic [TC_CODE_W-1:0]  tc_code,
  input  logic [PIX_W-1:0]      black_target,
  output logic [OFF_W-1:0]      offset_out
);
  localparam int STATE_W = OFF_W + FRAC_W;

  logic [PIX_W-1:0]          avg;
  logic                      line_full, take;
  logic signed [STATE_W-1:0] state;

  assign take = pix_valid && pix_ready && win_en;

  bla_window_avg #(.PIX_W(PIX_W)) u_win (
    .clk(clk), .rst_n(rst_n), .pix_data(pix_data), .take(take),
    .clamp(clamp_pulse), .line_end(line_end), .win_code(win_code),
    .avg(avg), .line_full(line_full)
  );

  bla_loop_filter #(.PIX_W(PIX_W), .STATE_W(STATE_W)) u_filt (
    .clk(clk), .rst_n(rst_n), .avg(avg), .target(black_target),
    .line_end(line_end), .line_full(line_full), .loop_off(loop_off),
    .tc_code(tc_code), .state(state)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_ready  <= 1'b0;
      offset_out <= '0;
    end else begin
      pix_ready <= 1'b1;
      if (clamp_pulse) offset_out <= state[STATE_W-1 -: OFF_W];
    end
  end

  AST_OUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !clamp_pulse |=> $stable(offset_out));  // R5
endmodule

// File: tb/bla_offset_loop_tb.sv
module bla_offset_loop_tb;
  logic       clk = 0, rst_n = 0;
  logic [7:0] pix_data = 0, black_target = 0;
  logic       pix_valid = 0, win_en = 0, line_end = 0, clamp_pulse = 0, loop_off = 0;
  logic [1:0] win_code = 0;
  logic [2:0] tc_code = 0;
  logic       pix_ready;
  logic [9:0] offset_out;

  int checks = 0, errors = 0, cycles = 0;
  longint filt_m = 0, sum_m = 0, exp_off = 0;
  int cnt_m = 0;
  int unsigned seed_dummy;

  bla_offset_loop u_dut (.*);

  always #10 clk = ~clk;  // 50 MHz

  function automatic longint sat(longint x);
    if (x > 2097151) return 2097151;
    if (x < -2097152) return -2097152;
    return x;
  endfunction

  function automatic int win_n(logic [1:0] c);
    return 16 << c;
  endfunction

  function automatic longint off_of(longint s);
    return s >>> 12;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      summary();
    end
  end

  task automatic clamp_line(string tag);
    @(negedge clk) clamp_pulse = 1;
    @(negedge clk) clamp_pulse = 0;
    exp_off = off_of(filt_m);
    cnt_m = 0; sum_m = 0;
    check(tag, longint'($signed(offset_out)), exp_off);
  endtask

  // deliver n counted-eligible samples in [lo,hi], optional valid gaps
  task automatic feed(int n, int lo, int hi, bit gaps);
    int given = 0;
    repeat (2) @(negedge clk);
    while (given < n) begin
      @(negedge clk);
      win_en = 1;
      pix_valid = gaps ? (($urandom % 4) != 0) : 1'b1;
      pix_data = 8'(lo + ($urandom % (hi - lo + 1)));
      if (pix_valid) begin
        given++;
        if (cnt_m < win_n(win_code)) begin
          cnt_m++;
          sum_m += pix_data;
        end
      end
    end
    @(negedge clk) begin win_en = 0; pix_valid = 0; end
  endtask

  task automatic end_line(string tag);
    @(negedge clk) line_end = 1;
    @(negedge clk) line_end = 0;
    if (cnt_m == win_n(win_code) && !loop_off)
      filt_m = sat(filt_m + (longint'(black_target) - (sum_m >>> (4 + win_code)))
                            * (longint'(1) << (7 - tc_code)));
    cnt_m = 0; sum_m = 0;
    check(tag, longint'($signed(offset_out)), exp_off);
  endtask

  initial begin
    seed_dummy = $urandom(1234);
    repeat (3) @(negedge clk);
    check("R1 offset in reset", longint'(offset_out), 0);
    check("R1 ready in reset", longint'(pix_ready), 0);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    check("R10 ready after reset", longint'(pix_ready), 1);
    clamp_line("R1 state zero after reset");

    // R3: 16 samples summing 120 give average 7 (floor of 7.5)
    win_code = 0; tc_code = 0; black_target = 71;
    clamp_line("R6 clamp opens line");
    repeat (2) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk) begin win_en = 1; pix_valid = 1; pix_data = 8'(i); end
    end
    @(negedge clk) begin win_en = 0; pix_valid = 0; end
    cnt_m = 16; sum_m = 120;
    end_line("R5 no change at line end");
    clamp_line("R3 floor average into filter");
    check("R3 expected offset 2", longint'($signed(offset_out)), 2);

    // R2: overfilled window, extra outliers ignored
    win_code = 1; black_target = 40;
    clamp_line("R6 clamp opens line");
    feed(32, 20, 20, 0);
    feed(10, 255, 255, 0);
    end_line("R5 no change at line end");
    clamp_line("R2 extras ignored");

    // R7: short line discarded
    win_code = 2; black_target = 200;
    clamp_line("R6 clamp opens line");
    feed(40, 0, 10, 1);
    end_line("R7 short line");
    clamp_line("R7 state unchanged after short line");

    // R8: disabled loop freezes state
    loop_off = 1; win_code = 0;
    clamp_line("R6 clamp opens line");
    feed(16, 0, 0, 0);
    end_line("R8 line while off");
    clamp_line("R8 offset reloaded from frozen state");
    loop_off = 0;

    // R9: positive saturation
    win_code = 0; tc_code = 0; black_target = 255;
    repeat (80) begin
      clamp_line("R5 clamp reload");
      feed(16, 0, 0, 0);
      end_line("R5 hold");
    end
    clamp_line("R9 positive limit");
    check("R9 offset at +511", longint'($signed(offset_out)), 511);

    // R9: negative saturation
    black_target = 0;
    repeat (140) begin
      clamp_line("R5 clamp reload");
      feed(16, 255, 255, 0);
      end_line("R5 hold");
    end
    clamp_line("R9 negative limit");
    check("R9 offset at -512", longint'($signed(offset_out)), -512);

    // R4: random lines across all codes
    for (int k = 0; k < 150; k++) begin
      int lo, n;
      win_code = 2'($urandom % 4);
      tc_code = 3'($urandom % 8);
      black_target = 8'($urandom);
      loop_off = (($urandom % 8) == 0);
      lo = $urandom % 200;
      n = win_n(win_code);
      if (($urandom % 8) == 0) n = n - 1 - ($urandom % 8);
      clamp_line("R4 random line reload");
      feed(n, lo, lo + ($urandom % 56), 1);
      end_line("R4 random line end hold");
    end
    loop_off = 0;
    clamp_line("R4 final reload");
    check("R10 ready stays high", longint'(pix_ready), 1);
    summary();
  end
endmodule